// File: doc/BRIEF.md
# Decimating Triggered Record Controller

This block captures one triggered record from a continuous sample stream that can be thinned by a decimation factor. Software programs three values: how many kept samples to show before the trigger, how many to show from the trigger on, and the decimation factor. An input strobe marks the cycles that carry a sample. Of those samples, the block keeps the first one after arming and then one in every *factor*. Only kept samples are written into the history, counted toward the record length or emitted.

The history is a delay line that always lags the newest kept sample by the programmed pre-trigger count. After arming, the block waits until that many kept samples have been seen. It then accepts a trigger. From that point on, each kept sample pushes one delayed sample out to the packing logic downstream. The first beat out is the oldest pre-trigger sample and carries a start-of-record flag. The last beat carries an end-of-record flag. The block then stays idle until it is re-armed.

Top module: `trig_record_ctrl`

## Requirements
- R1: An accepted arm latches the three configuration values and restarts the decimation phase. The first valid input after arming is kept, and after that every `cfg_dec`-th valid input is kept. A factor of 0 or 1 keeps every valid input.
- R2: A trigger that arrives before `cfg_pre` kept samples have been collected since arming has no effect, and no beat is emitted.
- R3: Once the history is full, a trigger pulse is remembered. The first kept sample in the trigger cycle, or in any later cycle, becomes the first post-trigger sample, even when the trigger pulse fell on a cycle with no kept sample.
- R4: A record consists of the `cfg_pre` kept samples before the first post-trigger sample, followed by `cfg_post` kept samples starting with it, in arrival order. That is `cfg_pre + cfg_post` beats in total. A `cfg_post` of 0 is treated as 1.
- R5: `out_sor` is high on the first beat only, and `out_eor` is high on the last beat only. Both are high together when the record is one beat long.
- R6: `out_valid` rises exactly one cycle after an input cycle that carried a kept sample during the record. Cycles with no valid input, and valid inputs that decimation drops, do not advance the record.
- R7: Neither a trigger nor any kept sample that arrives after the trigger has been taken produces an extra beat. After end-of-record, no beat is emitted until the block is re-armed.
- R8: `arm` is honoured only when the block is idle after reset or has finished a record. An arm pulse while the block is filling, armed or streaming changes nothing.
- R9: Pre-trigger counts up to `DEPTH-1` are supported, where `DEPTH` must be a power of two.
- R10: While reset is asserted, and until the first record starts, `out_valid`, `out_sor` and `out_eor` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Start a new capture (latches configuration) |
| cfg_pre | input | $clog2(DEPTH) | Kept samples shown before the trigger |
| cfg_post | input | POST_W | Kept samples from the trigger on |
| cfg_dec | input | DEC_W | Decimation factor (0 treated as 1) |
| in_valid | input | 1 | Input cycle carries a sample |
| in_data | input | DATA_W | Input sample |
| trig | input | 1 | Trigger request |
| out_valid | output | 1 | Output beat valid |
| out_data | output | DATA_W | Output sample |
| out_sor | output | 1 | First beat of the record |
| out_eor | output | 1 | Last beat of the record |

## Verification
Two events can fall on the same beat: the start-of-record marker from trigger acceptance and the end-of-record marker from the length count. They coincide when the pre-trigger count is zero and the post-trigger count is one, or zero, which counts as one. The bench runs both of these configurations. It judges the result by requiring a single captured beat that carries both flags and the sample at the trigger point. Trigger acceptance can also fall on the same cycle as a kept sample, or on a cycle with none. Random valid densities produce both cases, and the bench checks the recorded data against the kept-sample index it has computed itself.

// File: rtl/trc_pkg.sv
`timescale 1ns/1ps
package trc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FILL  = 3'd1,
    ST_ARMED = 3'd2,
    ST_POST  = 3'd3,
    ST_DONE  = 3'd4
  } rec_state_e;
endpackage

// File: rtl/trc_rst_sync.sv
`timescale 1ns/1ps
module trc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain[STAGES-1];
endmodule

// File: rtl/trc_decimator.sv
`timescale 1ns/1ps
module trc_decimator #(
  parameter int DEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DEC_W-1:0] cfg_dec,
  input  logic             in_valid,
  output logic             kept
);
  logic [DEC_W-1:0] dec_q, dec_d;
  logic [DEC_W-1:0] phase_q, phase_d;
  logic [DEC_W-1:0] dec_eff;

  always_comb begin
    dec_eff = (dec_q == '0) ? DEC_W'(1) : dec_q;
    kept    = in_valid && (phase_q == '0);
    dec_d   = dec_q;
    phase_d = phase_q;
    if (restart) begin
      dec_d   = cfg_dec;
      phase_d = '0;
    end else if (in_valid) begin
      if (phase_q + DEC_W'(1) >= dec_eff) phase_d = '0;
      else                                phase_d = phase_q + DEC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q   <= DEC_W'(1);
      phase_q <= '0;
    end else begin
      dec_q   <= dec_d;
      phase_q <= phase_d;
    end
  end
endmodule

// File: rtl/trc_history.sv
`timescale 1ns/1ps
module trc_history #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 128,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     lag,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr_q, wptr_d;
  logic [AW-1:0]     rd_addr;

  always_comb begin
    wptr_d  = wr_en ? wptr_q + AW'(1) : wptr_q;
    rd_addr = wptr_q - lag;
  end

  generate
    if (DEPTH > 1) begin : g_lagged
      assign rd_data = (lag == '0) ? wr_data : mem[rd_addr];
    end else begin : g_direct
      assign rd_data = wr_data;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wptr_q <= '0;
    else        wptr_q <= wptr_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr_q] <= wr_data;
  end
endmodule

// File: rtl/trc_fsm.sv
`timescale 1ns/1ps
module trc_fsm
  import trc_pkg::*;
#(
  parameter int PRE_W  = 7,
  parameter int POST_W = 16,
  parameter int TOT_W  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              trig,
  input  logic              kept,
  input  logic [PRE_W-1:0]  cfg_pre,
  input  logic [POST_W-1:0] cfg_post,
  output logic              restart,
  output logic              emit,
  output logic              first,
  output logic              last,
  output rec_state_e        state,
  output logic [PRE_W-1:0]  pre_q,
  output logic [TOT_W-1:0]  tot_q
);
  rec_state_e        state_d;
  logic              pend_q, pend_d;
  logic [PRE_W-1:0]  fill_q, fill_d;
  logic [TOT_W-1:0]  beat_q, beat_d;
  logic [TOT_W-1:0]  beat_idx;
  logic [POST_W-1:0] post_eff;
  logic              start;

  always_comb begin
    restart  = arm && (state == ST_IDLE || state == ST_DONE);
    start    = (state == ST_ARMED) && kept && (trig || pend_q);
    emit     = start || ((state == ST_POST) && kept);
    first    = start;
    beat_idx = start ? '0 : beat_q;
    last     = emit && (beat_idx == tot_q - TOT_W'(1));
    post_eff = (cfg_post == '0) ? POST_W'(1) : cfg_post;

    state_d = state;
    case (state)
      ST_IDLE:  if (restart) state_d = ST_FILL;
      ST_FILL:  if (fill_q == pre_q) state_d = ST_ARMED;
      ST_ARMED: if (start) state_d = last ? ST_DONE : ST_POST;
      ST_POST:  if (last) state_d = ST_DONE;
      ST_DONE:  if (restart) state_d = ST_FILL;
      default:  state_d = ST_IDLE;
    endcase

    pend_d = (state == ST_ARMED) ? ((pend_q || trig) && !start) : 1'b0;

    fill_d = fill_q;
    if (restart) fill_d = '0;
    else if ((state == ST_FILL) && kept && (fill_q != pre_q)) fill_d = fill_q + PRE_W'(1);

    beat_d = beat_q;
    if (start) beat_d = TOT_W'(1);
    else if ((state == ST_POST) && kept) beat_d = beat_q + TOT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      pend_q <= 1'b0;
      fill_q <= '0;
      beat_q <= '0;
      pre_q  <= '0;
      tot_q  <= TOT_W'(1);
    end else begin
      state  <= state_d;
      pend_q <= pend_d;
      fill_q <= fill_d;
      beat_q <= beat_d;
      if (restart) begin
        pre_q <= cfg_pre;
        tot_q <= TOT_W'(cfg_pre) + TOT_W'(post_eff);
      end
    end
  end
endmodule

// File: rtl/trig_record_ctrl.sv
`timescale 1ns/1ps
module trig_record_ctrl
  import trc_pkg::*;
#(
  parameter int  DATA_W = 16,
  parameter int  DEPTH  = 128,
  parameter int  POST_W = 16,
  parameter int  DEC_W  = 5,
  localparam int PRE_W  = $clog2(DEPTH),
  localparam int TOT_W  = ((PRE_W > POST_W) ? PRE_W : POST_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [PRE_W-1:0]  cfg_pre,
  input  logic [POST_W-1:0] cfg_post,
  input  logic [DEC_W-1:0]  cfg_dec,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              trig,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sor,
  output logic              out_eor
);
  logic              rst_n_sync;
  logic              kept;
  logic              restart;
  logic              emit;
  logic              first;
  logic              last;
  rec_state_e        state;
  logic [PRE_W-1:0]  pre_q;
  logic [TOT_W-1:0]  tot_q;
  logic [DATA_W-1:0] hist_data;

  trc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  trc_decimator #(.DEC_W(DEC_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .restart  (restart),
    .cfg_dec  (cfg_dec),
    .in_valid (in_valid),
    .kept     (kept)
  );

  trc_history #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_hist (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (kept),
    .wr_data (in_data),
    .lag     (pre_q),
    .rd_data (hist_data)
  );

  trc_fsm #(.PRE_W(PRE_W), .POST_W(POST_W), .TOT_W(TOT_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .arm      (arm),
    .trig     (trig),
    .kept     (kept),
    .cfg_pre  (cfg_pre),
    .cfg_post (cfg_post),
    .restart  (restart),
    .emit     (emit),
    .first    (first),
    .last     (last),
    .state    (state),
    .pre_q    (pre_q),
    .tot_q    (tot_q)
  );

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      out_valid <= 1'b0;
      out_sor   <= 1'b0;
      out_eor   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= emit;
      out_sor   <= first;
      out_eor   <= last;
      if (emit) out_data <= hist_data;
    end
  end
endmodule

// File: rtl/trc_checker.sv
`timescale 1ns/1ps
module trc_checker
  import trc_pkg::*;
#(
  parameter int TOT_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm,
  input logic             out_valid,
  input logic             out_sor,
  input logic             out_eor,
  input logic             kept,
  input rec_state_e       state,
  input logic [TOT_W-1:0] tot_q
);
  logic             in_rec;
  logic [TOT_W-1:0] beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_rec <= 1'b0;
      beats  <= '0;
    end else if (out_valid) begin
      in_rec <= !out_eor;
      beats  <= out_eor ? '0 : (out_sor ? TOT_W'(1) : beats + TOT_W'(1));
    end
  end

  // R5
  sor_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sor |-> out_valid);

  // R5
  eor_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_eor |-> out_valid);

  // R5
  no_nested_sor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sor |-> !in_rec);

  // R7
  beat_inside_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sor) |-> in_rec);

  // R6
  beat_follows_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(kept));

  // R4
  record_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_eor |-> (((out_sor ? '0 : beats) + TOT_W'(1)) == tot_q));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && !arm) |=> (state == ST_DONE));
endmodule

bind trig_record_ctrl trc_checker #(.TOT_W(TOT_W)) u_trc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .arm       (arm),
  .out_valid (out_valid),
  .out_sor   (out_sor),
  .out_eor   (out_eor),
  .kept      (kept),
  .state     (state),
  .tot_q     (tot_q)
);

// File: tb/trig_record_ctrl_test.sv
`timescale 1ns/1ps
module trig_record_ctrl_test;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 128;
  localparam int POST_W = 16;
  localparam int DEC_W  = 5;
  localparam int PRE_W  = 7;
  localparam int CAPN   = 1024;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              arm;
  logic [PRE_W-1:0]  cfg_pre;
  logic [POST_W-1:0] cfg_post;
  logic [DEC_W-1:0]  cfg_dec;
  logic              in_valid;
  logic [DATA_W-1:0] in_data;
  logic              trig;
  logic              out_valid;
  logic [DATA_W-1:0] out_data;
  logic              out_sor;
  logic              out_eor;

  int n_chk = 0;
  int n_bad = 0;
  int cap_n = 0;
  bit saw_eor = 0;
  bit cur_kept = 0;
  int nvalid = 0;
  int nkept = 0;
  int dec_e = 1;
  logic [DATA_W-1:0] cap_d [CAPN];
  bit cap_s [CAPN];
  bit cap_e [CAPN];

  always #10 clk = ~clk;

  trig_record_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .POST_W(POST_W), .DEC_W(DEC_W)) uut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_pre(cfg_pre), .cfg_post(cfg_post),
    .cfg_dec(cfg_dec), .in_valid(in_valid), .in_data(in_data), .trig(trig),
    .out_valid(out_valid), .out_data(out_data), .out_sor(out_sor), .out_eor(out_eor)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit pick(input int pct);
    return ($urandom % 100) < pct;
  endfunction

  function automatic int exp_sample(input int kidx);
    return (kidx * dec_e) & 16'hFFFF;
  endfunction

  // R6: every beat must follow a cycle whose input the bench model marks as kept
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      chk(cur_kept, "R6 beat after kept input", 0, 1);
      if (cap_n < CAPN) begin
        cap_d[cap_n] = out_data;
        cap_s[cap_n] = out_sor;
        cap_e[cap_n] = out_eor;
      end
      cap_n++;
      if (out_eor) saw_eor = 1;
    end
  end

  task automatic step(input bit v, input bit t, input bit a);
    @(negedge clk);
    #1;
    in_valid = v;
    trig     = t;
    arm      = a;
    in_data  = v ? DATA_W'(nvalid) : DATA_W'($urandom);
    cur_kept = 0;
    if (v) begin
      cur_kept = ((nvalid % dec_e) == 0);
      if (cur_kept) nkept++;
      nvalid++;
    end
  endtask

  task automatic run_record(input int pre, input int post, input int dec, input int pv,
                            input bit early, input bit arm_post);
    int k, tot, lim, base;
    bit firstc;
    string req;
    cfg_pre  = PRE_W'(pre);
    cfg_post = POST_W'(post);
    cfg_dec  = DEC_W'(dec);
    dec_e    = (dec == 0) ? 1 : dec;
    tot      = pre + ((post == 0) ? 1 : post);
    req      = arm_post ? "R8" : "R4";
    cap_n    = 0;
    saw_eor  = 0;
    step(0, 0, 1);
    nvalid = 0;
    nkept  = 0;
    firstc = 1;
    while (nkept < pre) begin
      step(pick(pv), early && firstc, 0);
      firstc = 0;
    end
    step(0, 0, 0);
    step(0, 0, 0);
    // R2: nothing leaves before an accepted trigger
    chk(cap_n == 0, "R2 no beat before trigger", cap_n, 0);
    k = nkept;
    step(pick(pv), 1, 0);
    lim = 0;
    while (!saw_eor && lim < 40000) begin
      step(pick(pv), ($urandom % 8) == 0, arm_post && (lim == 3));
      lim++;
    end
    repeat (30) step(pick(pv), ($urandom % 3) == 0, 0);
    // R7: stray triggers and samples after the record add no beats
    chk(cap_n == tot, "R7 no beats after end", cap_n, tot);
    chk(cap_n == tot, req, cap_n, tot);
    base = k - pre;
    for (int b = 0; b < tot && b < cap_n && b < CAPN; b++) begin
      // R1 R3: beat b is kept sample base+b
      chk(int'(cap_d[b]) == exp_sample(base + b), "R1 R3 data", cap_d[b], exp_sample(base + b));
      chk(cap_s[b] == (b == 0), "R5 sor", cap_s[b], (b == 0));
      chk(cap_e[b] == (b == tot - 1), "R5 eor", cap_e[b], (b == tot - 1));
    end
  endtask

  initial begin
    int seed, dsel, dec;
    seed = $urandom(32'd7771);
    rst_n = 0; arm = 0; trig = 0; in_valid = 0; in_data = '0;
    cfg_pre = '0; cfg_post = '0; cfg_dec = '0;
    repeat (3) @(negedge clk);
    // R10: outputs low while reset is held
    chk(!out_valid && !out_sor && !out_eor, "R10 reset outputs", {out_valid, out_sor, out_eor}, 0);
    rst_n = 1;
    repeat (4) step(1, 1, 0);
    step(0, 0, 0);
    // R10: idle block ignores samples and triggers before any arm
    chk(cap_n == 0, "R10 idle no beats", cap_n, 0);
    chk(!out_valid && !out_sor && !out_eor, "R10 idle outputs", {out_valid, out_sor, out_eor}, 0);

    run_record(100, 200, 12, 70, 1, 0);
    run_record(0, 1, 1, 100, 0, 0);
    run_record(0, 0, 4, 60, 0, 0);
    run_record(5, 0, 3, 60, 1, 0);
    // R9: deepest history
    run_record(127, 40, 2, 80, 1, 0);
    run_record(10, 20, 0, 50, 0, 1);
    run_record(3, 8, 1, 100, 1, 1);
    for (int i = 0; i < 8; i++) begin
      dsel = $urandom % 6;
      dec  = (dsel == 0) ? 0 : (dsel == 1) ? 1 : (dsel == 2) ? 2 :
             (dsel == 3) ? 3 : (dsel == 4) ? 5 : 12;
      run_record($urandom % 40, 1 + ($urandom % 60), dec, 30 + ($urandom % 70),
                 $urandom % 2, $urandom % 2);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 180000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule